// File: doc/BRIEF.md
# USB OTG Hardware-Assist Sequencer

This block takes three timing-critical On-The-Go chores away from software, whose interrupt latency could otherwise break protocol timing. First, when automatic reset is enabled, a device connect makes the block start a port reset at once and time it. When that reset ends, the block raises an enable-change status bit and a port-change interrupt pulse. Second, a one-cycle write strobe launches a data pulse on DP, held for a fixed 7 ms, and the block then releases DP by itself. Third, when the port is suspended and the device disconnects, the block hands the port over from the host role to the peripheral role in a fixed order.

A count of CLK_PER_MS clock cycles makes one millisecond, and every duration is derived from that count. Software can read the status outputs. It acknowledges the sticky bits through a clear vector. Connect events are always reported, whether or not automatic reset is enabled.

Top module: `otg_assist`

## Requirements
- R1: While rst_ni is low, and after it is released with no stimulus, every output is 0.
- R2: A connect_i pulse seen while auto_rst_en_i is 1 and no reset is running sets port_rst_o in the next cycle, which is well inside 1 ms. A connect with auto_rst_en_i at 0 never sets port_rst_o.
- R3: Every connect_i pulse sets the sticky conn_chg_o bit in the next cycle, whatever the value of auto_rst_en_i.
- R4: port_rst_o stays high for exactly RST_MS*CLK_PER_MS cycles. In the cycle it falls, en_chg_o becomes 1 and port_chg_irq_o is high for that one cycle only.
- R5: A connect_i pulse while port_rst_o is high neither restarts nor lengthens the reset.
- R6: A dp_pulse_wr_i strobe while no pulse runs sets dp_pulse_o in the next cycle. dp_pulse_o then stays high for exactly 7*CLK_PER_MS cycles (between 5 ms and 10 ms) and returns to 0 by itself.
- R7: A dp_pulse_wr_i strobe while dp_pulse_o is high is ignored: the pulse still ends at its original time.
- R8: The role switch starts only in a cycle where role_sw_en_i, port_suspend_i and disconnect_i are all 1. With any of the three missing, no role output changes.
- R9: Once started, the role outputs move one step per cycle in this order: otg_ctrl_rst_o high for one cycle, then dev_mode_o, then dev_run_o, then irq_en_o = 3'b111 (bit 0 bus reset, bit 1 suspend, bit 2 port change). Each level stays set.
- R10: dp_pullup_o rises 5 cycles after the triggering disconnect, far inside 3 ms, and stays on together with the peripheral role until reset.
- R11: sts_clr_i[0] clears conn_chg_o and sts_clr_i[1] clears en_chg_o in the next cycle. A set and a clear in the same cycle leave the bit at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| auto_rst_en_i | input | 1 | Enable for the automatic port reset on connect |
| connect_i | input | 1 | One-cycle device connect event |
| sts_clr_i | input | 2 | Write-1-to-clear: [0] connect change, [1] enable change |
| dp_pulse_wr_i | input | 1 | One-cycle strobe that starts a data pulse |
| role_sw_en_i | input | 1 | Enable for the disconnect-to-peripheral role switch |
| port_suspend_i | input | 1 | Host port is suspended |
| disconnect_i | input | 1 | One-cycle device disconnect event |
| port_rst_o | output | 1 | Port reset drive |
| conn_chg_o | output | 1 | Sticky connect-change status |
| en_chg_o | output | 1 | Sticky port enable-change status |
| port_chg_irq_o | output | 1 | One-cycle port-change interrupt |
| dp_pulse_o | output | 1 | DP data-pulse drive and busy status |
| otg_ctrl_rst_o | output | 1 | One-cycle OTG controller reset |
| dev_mode_o | output | 1 | Peripheral (device) mode select |
| dev_run_o | output | 1 | Device run bit |
| irq_en_o | output | 3 | Interrupt enables: [0] bus reset, [1] suspend, [2] port change |
| dp_pullup_o | output | 1 | DP pull-up enable in the peripheral role |

## Verification
Every response is registered, so each result appears one clock edge after the input that causes it. A status bit, port_rst_o, dp_pulse_o and the first role step all follow the sampling edge directly. The falls come exactly RST_MS*CLK_PER_MS and 7*CLK_PER_MS edges after the rise. The role steps follow on the four next edges, with the pull-up on the fifth. The bench drives inputs 2 ns after a rising edge, steps a behavioural model on the same rising edge, and compares all outputs at the falling edge, so each comparison lands in the cycle in which the result is due. Run-length monitors and directed probes at the exact end cycles also confirm the restart, ignore and start-condition cases.

// File: rtl/otg_assist_pkg.sv
package otg_assist_pkg;
  localparam int unsigned IEN_W = 3;

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_CRST,
    RS_MODE,
    RS_RUN,
    RS_IEN,
    RS_DONE
  } role_st_e;
endpackage

// File: rtl/otg_auto_rst.sv
module otg_auto_rst #(
  parameter int unsigned CYC = 2000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       connect_i,
  input  logic [1:0] clr_i,
  output logic       port_rst_o,
  output logic       conn_chg_o,
  output logic       en_chg_o,
  output logic       irq_o
);
  localparam int unsigned CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          rst_q, conn_q, chg_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      rst_q  <= 1'b0;
      conn_q <= 1'b0;
      chg_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (clr_i[0]) conn_q <= 1'b0;
      if (connect_i) conn_q <= 1'b1;
      if (clr_i[1]) chg_q <= 1'b0;
      if (rst_q) begin
        if (cnt_q == CW'(CYC - 1)) begin
          rst_q <= 1'b0;
          chg_q <= 1'b1;
          irq_q <= 1'b1;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (en_i && connect_i) begin
        rst_q <= 1'b1;
        cnt_q <= '0;
      end
    end
  end

  assign port_rst_o = rst_q;
  assign conn_chg_o = conn_q;
  assign en_chg_o   = chg_q;
  assign irq_o      = irq_q;

  a_r2_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && connect_i && !rst_q) |=> rst_q);
  a_r4_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);
  a_r4_irq_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_q) |-> (irq_q && chg_q));
  a_r3_conn_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    connect_i |=> conn_q);
endmodule

// File: rtl/otg_data_pulse.sv
module otg_data_pulse #(
  parameter int unsigned CYC = 7000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  output logic dp_o
);
  localparam int unsigned CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          dp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dp_q  <= 1'b0;
    end else if (dp_q) begin
      if (cnt_q == CW'(CYC - 1)) begin
        dp_q  <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (wr_i) begin
      dp_q  <= 1'b1;
      cnt_q <= '0;
    end
  end

  assign dp_o = dp_q;

  // independent run-length counter for the pulse window
  logic [CW-1:0] len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   len_q <= '0;
    else if (dp_q) len_q <= len_q + 1'b1;
    else           len_q <= '0;
  end

  a_r6_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dp_q) |-> (len_q == CW'(CYC)));
  a_r7_no_early_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dp_q && len_q < CW'(CYC - 1)) |=> dp_q);
endmodule

// File: rtl/otg_role_switch.sv
module otg_role_switch
  import otg_assist_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             suspend_i,
  input  logic             disconnect_i,
  output logic             ctrl_rst_o,
  output logic             dev_mode_o,
  output logic             run_o,
  output logic [IEN_W-1:0] ien_o,
  output logic             pullup_o
);
  role_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      RS_IDLE: if (en_i && suspend_i && disconnect_i) st_d = RS_CRST;
      RS_CRST: st_d = RS_MODE;
      RS_MODE: st_d = RS_RUN;
      RS_RUN:  st_d = RS_IEN;
      RS_IEN:  st_d = RS_DONE;
      default: st_d = RS_DONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= RS_IDLE;
    else         st_q <= st_d;
  end

  assign ctrl_rst_o = (st_q == RS_CRST);
  assign dev_mode_o = (st_q == RS_MODE) || (st_q == RS_RUN) ||
                      (st_q == RS_IEN)  || (st_q == RS_DONE);
  assign run_o      = (st_q == RS_RUN) || (st_q == RS_IEN) || (st_q == RS_DONE);
  assign ien_o      = ((st_q == RS_IEN) || (st_q == RS_DONE)) ? '1 : '0;
  assign pullup_o   = (st_q == RS_DONE);

  a_r8_needs_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == RS_IDLE && !(en_i && suspend_i && disconnect_i)) |=> (st_q == RS_IDLE));
  a_r9_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rst_o |=> (dev_mode_o && !run_o && !ctrl_rst_o));
  a_r9_run_after_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_o) |-> $past(dev_mode_o));
  a_r10_pullup_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pullup_o |=> (pullup_o && dev_mode_o));
endmodule

// File: rtl/otg_assist.sv
module otg_assist
  import otg_assist_pkg::*;
#(
  parameter int unsigned CLK_PER_MS = 1000,
  parameter int unsigned RST_MS     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             auto_rst_en_i,
  input  logic             connect_i,
  input  logic [1:0]       sts_clr_i,
  input  logic             dp_pulse_wr_i,
  input  logic             role_sw_en_i,
  input  logic             port_suspend_i,
  input  logic             disconnect_i,
  output logic             port_rst_o,
  output logic             conn_chg_o,
  output logic             en_chg_o,
  output logic             port_chg_irq_o,
  output logic             dp_pulse_o,
  output logic             otg_ctrl_rst_o,
  output logic             dev_mode_o,
  output logic             dev_run_o,
  output logic [IEN_W-1:0] irq_en_o,
  output logic             dp_pullup_o
);
  localparam int unsigned RST_CYC   = RST_MS * CLK_PER_MS;
  localparam int unsigned PULSE_CYC = 7 * CLK_PER_MS;

  otg_auto_rst #(.CYC(RST_CYC)) u_auto_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (auto_rst_en_i),
    .connect_i  (connect_i),
    .clr_i      (sts_clr_i),
    .port_rst_o (port_rst_o),
    .conn_chg_o (conn_chg_o),
    .en_chg_o   (en_chg_o),
    .irq_o      (port_chg_irq_o)
  );

  otg_data_pulse #(.CYC(PULSE_CYC)) u_data_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (dp_pulse_wr_i),
    .dp_o   (dp_pulse_o)
  );

  otg_role_switch u_role_switch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (role_sw_en_i),
    .suspend_i    (port_suspend_i),
    .disconnect_i (disconnect_i),
    .ctrl_rst_o   (otg_ctrl_rst_o),
    .dev_mode_o   (dev_mode_o),
    .run_o        (dev_run_o),
    .ien_o        (irq_en_o),
    .pullup_o     (dp_pullup_o)
  );

  a_r1_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dev_mode_o) |-> (!dev_run_o && irq_en_o == '0 && !dp_pullup_o));
endmodule

// File: tb/test_otg_assist.sv
module test_otg_assist;
  localparam int CPM   = 10;
  localparam int RMS   = 2;
  localparam int RCYC  = RMS * CPM;
  localparam int PCYC  = 7 * CPM;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic auto_en = 0, conn = 0, dpwr = 0, rsen = 0, susp = 0, disc = 0;
  logic [1:0] clr = 2'b00;
  logic port_rst, conn_chg, en_chg, irq, dp, crst, dmode, drun, pull;
  logic [2:0] ien;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  otg_assist #(.CLK_PER_MS(CPM), .RST_MS(RMS)) i_otg_assist (
    .clk_i(clk), .rst_ni(rst_n), .auto_rst_en_i(auto_en), .connect_i(conn),
    .sts_clr_i(clr), .dp_pulse_wr_i(dpwr), .role_sw_en_i(rsen),
    .port_suspend_i(susp), .disconnect_i(disc), .port_rst_o(port_rst),
    .conn_chg_o(conn_chg), .en_chg_o(en_chg), .port_chg_irq_o(irq),
    .dp_pulse_o(dp), .otg_ctrl_rst_o(crst), .dev_mode_o(dmode),
    .dev_run_o(drun), .irq_en_o(ien), .dp_pullup_o(pull)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference
  bit m_prst, m_conn, m_chg, m_irq, m_dp;
  int m_left, m_dleft, m_step;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_prst = 0; m_conn = 0; m_chg = 0; m_irq = 0; m_dp = 0;
      m_left = 0; m_dleft = 0; m_step = 0;
    end else begin
      m_irq = 0;
      if (clr[0]) m_conn = 0;
      if (conn) m_conn = 1;
      if (clr[1]) m_chg = 0;
      if (m_prst) begin
        m_left--;
        if (m_left == 0) begin m_prst = 0; m_chg = 1; m_irq = 1; end
      end else if (conn && auto_en) begin
        m_prst = 1; m_left = RCYC;
      end
      if (m_dp) begin
        m_dleft--;
        if (m_dleft == 0) m_dp = 0;
      end else if (dpwr) begin
        m_dp = 1; m_dleft = PCYC;
      end
      if (m_step == 0) begin
        if (rsen && susp && disc) m_step = 1;
      end else if (m_step < 5) m_step++;
    end
  end

  // run-length monitors for R5 / R7
  int rst_run = 0, dp_run = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2", "port_rst", port_rst, m_prst);
      chk("R3", "conn_chg", conn_chg, m_conn);
      chk("R4", "en_chg", en_chg, m_chg);
      chk("R4", "irq", irq, m_irq);
      chk("R6", "dp_pulse", dp, m_dp);
      chk("R9", "ctrl_rst", crst, m_step == 1);
      chk("R9", "dev_mode", dmode, m_step >= 2);
      chk("R9", "dev_run", drun, m_step >= 3);
      chk("R9", "irq_en", ien, (m_step >= 4) ? 7 : 0);
      chk("R10", "pullup", pull, m_step >= 5);
      if (port_rst) rst_run++;
      else begin
        if (rst_run != 0) chk("R5", "reset length", rst_run, RCYC);
        rst_run = 0;
      end
      if (dp) dp_run++;
      else begin
        if (dp_run != 0) chk("R7", "pulse length", dp_run, PCYC);
        dp_run = 0;
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pulse_conn();
    conn = 1; cyc(1); conn = 0;
  endtask

  initial begin
    cyc(3);
    // R1: outputs while in reset
    chk("R1", "outs in reset",
        {port_rst, conn_chg, en_chg, irq, dp, crst, dmode, drun, ien, pull}, 0);
    rst_n = 1;
    cyc(2);
    chk("R1", "outs after release",
        {port_rst, conn_chg, en_chg, irq, dp, crst, dmode, drun, ien, pull}, 0);

    // R2 negative, R3: connect without auto reset
    pulse_conn();
    cyc(3);
    chk("R2", "no auto reset when disabled", port_rst, 0);
    chk("R3", "connect reported", conn_chg, 1);
    clr = 2'b01; cyc(1); clr = 2'b00;
    #1 chk("R11", "conn cleared", conn_chg, 0);

    // R2, R4, R5: auto reset, second connect mid-reset
    auto_en = 1;
    pulse_conn();
    #1 chk("R2", "reset started next cycle", port_rst, 1);
    cyc(5);
    pulse_conn();
    cyc(RCYC + 5);
    chk("R5", "reset ended, not restarted", port_rst, 0);
    chk("R4", "enable change set", en_chg, 1);

    // R11: clear and set in same cycle, set wins
    clr = 2'b01; conn = 1; auto_en = 0; cyc(1); clr = 2'b00; conn = 0;
    #1 chk("R11", "set beats clear", conn_chg, 1);
    clr = 2'b10; cyc(1); clr = 2'b00;
    #1 chk("R11", "en_chg cleared", en_chg, 0);

    // R6, R7: data pulse with a repeated write
    dpwr = 1; cyc(1); dpwr = 0;
    #1 chk("R6", "pulse started", dp, 1);
    cyc(10);
    dpwr = 1; cyc(1); dpwr = 0;
    cyc(PCYC - 12);
    #1 chk("R7", "pulse still high before end", dp, 1);
    cyc(1);
    #1 chk("R7", "pulse ended on time", dp, 0);
    cyc(5);

    // R8: partial trigger conditions
    rsen = 1; susp = 0; disc = 1; cyc(1); disc = 0; cyc(4);
    chk("R8", "no start without suspend", dmode, 0);
    rsen = 0; susp = 1; disc = 1; cyc(1); disc = 0; cyc(4);
    chk("R8", "no start without enable", dmode, 0);
    rsen = 1; cyc(4);
    chk("R8", "no start without disconnect", dmode, 0);

    // R9, R10: full role switch
    disc = 1; cyc(1); disc = 0;
    #1 chk("R9", "controller reset first", crst, 1);
    cyc(4);
    #1 chk("R10", "pullup after 5 cycles", pull, 1);
    cyc(10);
    chk("R10", "role held", {dmode, drun, ien, pull}, 6'b111111);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule